// File: doc/BRIEF.md
# Programmable Differential Clock Post-Scaler with Load Divider Chain

This block takes a fast source clock and builds three outputs from it. The first is a complementary clock pair whose rate is the source divided by 1, 2 or 4. The second is a LOAD strobe from a programmable first divider. The third comes from a second divider that counts LOAD transitions. The whole block runs in one clock domain. The source clock is modelled as a square wave that toggles once per tick, so one source period lasts two ticks. A tick is one `clk_i` cycle. When reference select is on, a tick is instead one rising edge of `ref_clk_i`, and that input is synchronised into the domain first.

Software sets a manual mode, in which two control bits drive the clock pair and LOAD directly. A jam bit parks the post-scaler and the second divider. A hold bit freezes the pair at a fixed level. Once hold is released, the pair stays frozen until the next rising edge of the second divider's output, so the restart lines up with that divider. Every new divider setting waits for the terminal count of its own divider before it applies, so no runt phase is ever produced.

Top module: `diffclk_scaler`

## Requirements
- R1: While `rst_ni` is low, `clk_p_o`=0, `clk_n_o`=1, `load_o`=0 and `n2_o`=0.
- R2: With `post_sel_i` set to 00, 01 or 10, each high and each low phase of `clk_p_o` lasts 1, 2 or 4 ticks respectively.
- R3: Each phase of `load_o` lasts `n1_mod_i` ticks. A modulus of 0 acts as 1.
- R4: Each phase of `n2_o` lasts `n2_mod_i` phases of `load_o`. A modulus of 0 acts as 1.
- R5: With `post_sel_i`=11 (manual mode), `clk_p_o` equals the `aux_clk_i` value present before the last clock edge, and `load_o` equals `aux_load_i` in the same way. `n2_o` still divides the transitions of `load_o`.
- R6: Outside manual mode, `aux_load_i`=1 replaces the first modulus with 2, so each phase of `load_o` lasts 2 ticks. `aux_clk_i` has no effect there.
- R7: `clk_n_o` is always the complement of `clk_p_o`.
- R8: One cycle after `hold_i` is sampled high, `clk_p_o`=1 and `clk_n_o`=0. `load_o` keeps its normal period during hold.
- R9: After `hold_i` returns low, the pair stays at 1/0 through the cycle in which `n2_o` next rises. It resumes at most 3 cycles later.
- R10: While `jam_i` is high, `clk_p_o`=0 and `n2_o`=0, and `load_o` keeps dividing.
- R11: With `ref_sel_i`=1, ticks are rising edges of `ref_clk_i`. Both the post-scaler and the first divider count these edges instead of `clk_i` cycles.
- R12: A change of `post_sel_i` in the middle of a phase leaves that phase at its old length. The new ratio applies from the next phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | Alternate reference, sampled |
| ref_sel_i | input | 1 | Count reference edges instead of source cycles |
| post_sel_i | input | 2 | Post-scale ratio; 11 selects manual mode |
| aux_clk_i | input | 1 | Manual-mode level for the clock pair |
| aux_load_i | input | 1 | Manual-mode LOAD level, or divide-by-two override outside it |
| jam_i | input | 1 | Holds post-scaler and second divider cleared |
| hold_i | input | 1 | Freezes the pair at 1/0 |
| n1_mod_i | input | N1_W | First divider modulus |
| n2_mod_i | input | N2_W | Second divider modulus |
| clk_p_o | output | 1 | Positive clock output |
| clk_n_o | output | 1 | Negative clock output |
| load_o | output | 1 | First divider output |
| n2_o | output | 1 | Second divider output |

## Verification
The bench changes the ratio partway through a phase. A design that applies the new ratio at once would cut that phase short and produce a runt. After hold is released, the bench watches every cycle until the second divider rises. A design that resumes as soon as hold drops, or never resumes, is caught there. The bench also covers a zero modulus, the override bit in both modes, and jam. A design that stops LOAD during jam, or lets the jammed counters run, produces a wrong phase length or a wrong parked level. With the reference selected, the measured phase lengths scale by the reference period, which exposes a tick source that ignores the select.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int PS_W = 3;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV2   = 2'b01,
        PS_DIV4   = 2'b10,
        PS_MANUAL = 2'b11
    } ps_mode_e;

    typedef struct packed {
        logic     clk_p;
        logic     clk_n;
        logic     load;
        logic     n2;
        logic     armed;
        ps_mode_e mode;
    } top_st_t;

    function automatic logic [PS_W-1:0] ps_limit(input ps_mode_e m);
        case (m)
            PS_DIV2: ps_limit = PS_W'(2);
            PS_DIV4: ps_limit = PS_W'(4);
            default: ps_limit = PS_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/dcs_tick_src.sv
module dcs_tick_src #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    input  logic sel_ref_i,
    output logic tick_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = ref_i;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_sync
        always_comb sh_d[g] = sh_q[g-1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    always_comb begin
        tick_o = sel_ref_i ? (sh_q[STAGES-1] & ~sh_q[STAGES]) : 1'b1;
    end
endmodule

// File: rtl/dcs_halfdiv.sv
module dcs_halfdiv #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] lim_i,
    output logic         out_o,
    output logic         tc_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
        logic         out;
    } hd_st_t;

    hd_st_t       s_d, s_q;
    logic [W-1:0] eff_lim;

    always_comb begin
        eff_lim = (s_q.lim == '0) ? W'(1) : s_q.lim;
        tc_o    = !clr_i && en_i && (s_q.cnt >= eff_lim - W'(1));
        s_d     = s_q;
        if (clr_i) begin
            s_d.cnt = '0;
            s_d.out = 1'b0;
            s_d.lim = lim_i;
        end else if (en_i) begin
            if (tc_o) begin
                s_d.cnt = '0;
                s_d.out = ~s_q.out;
                s_d.lim = lim_i;
            end else begin
                s_d.cnt = s_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign out_o = s_q.out;
endmodule

// File: rtl/diffclk_scaler.sv
module diffclk_scaler
    import dcs_pkg::*;
#(
    parameter int N1_W        = 8,
    parameter int N2_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ref_clk_i,
    input  logic            ref_sel_i,
    input  logic [1:0]      post_sel_i,
    input  logic            aux_clk_i,
    input  logic            aux_load_i,
    input  logic            jam_i,
    input  logic            hold_i,
    input  logic [N1_W-1:0] n1_mod_i,
    input  logic [N2_W-1:0] n2_mod_i,
    output logic            clk_p_o,
    output logic            clk_n_o,
    output logic            load_o,
    output logic            n2_o
);
    localparam top_st_t RST_ST = '{clk_p: 1'b0, clk_n: 1'b1, load: 1'b0,
                                   n2: 1'b0, armed: 1'b0, mode: PS_DIV1};

    top_st_t         s_d, s_q;
    logic            tick;
    logic            ps_out, ps_tc;
    logic            n1_out, n1_tc;
    logic            n2_out, n2_tc;
    logic [PS_W-1:0] ps_lim;
    logic [N1_W-1:0] n1_lim;
    logic            manual, load_w, n2_en, n2_rise, hold_act, src;

    dcs_tick_src #(.STAGES(SYNC_STAGES)) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ref_i     (ref_clk_i),
        .sel_ref_i (ref_sel_i),
        .tick_o    (tick)
    );

    always_comb begin
        ps_lim = ps_limit(ps_mode_e'(post_sel_i));
        n1_lim = aux_load_i ? N1_W'(2) : n1_mod_i;
    end

    dcs_halfdiv #(.W(PS_W)) u_post (
        .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (jam_i), .en_i (tick),
        .lim_i (ps_lim), .out_o (ps_out), .tc_o (ps_tc)
    );

    dcs_halfdiv #(.W(N1_W)) u_n1 (
        .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (1'b0), .en_i (tick),
        .lim_i (n1_lim), .out_o (n1_out), .tc_o (n1_tc)
    );

    dcs_halfdiv #(.W(N2_W)) u_n2 (
        .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (jam_i), .en_i (n2_en),
        .lim_i (n2_mod_i), .out_o (n2_out), .tc_o (n2_tc)
    );

    always_comb begin
        s_d      = s_q;
        manual   = (s_q.mode == PS_MANUAL);
        load_w   = manual ? aux_load_i : n1_out;
        n2_en    = (load_w != s_q.load);
        n2_rise  = n2_out & ~s_q.n2;
        hold_act = hold_i | s_q.armed;
        src      = manual ? aux_clk_i : ps_out;

        if (ps_tc || jam_i) s_d.mode = ps_mode_e'(post_sel_i);

        s_d.load = load_w;
        s_d.n2   = n2_out;

        if (hold_i)       s_d.armed = 1'b1;
        else if (n2_rise) s_d.armed = 1'b0;

        s_d.clk_p = hold_act ? 1'b1 : src;
        s_d.clk_n = hold_act ? 1'b0 : ~src;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= RST_ST;
        else         s_q <= s_d;
    end

    assign clk_p_o = s_q.clk_p;
    assign clk_n_o = s_q.clk_n;
    assign load_o  = s_q.load;
    assign n2_o    = s_q.n2;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic hold_i,
    input logic jam_i,
    input logic clk_p_o,
    input logic clk_n_o,
    input logic n2_o
);
    assert_pair_complement_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_n_o == !clk_p_o);

    assert_hold_forces_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (clk_p_o && !clk_n_o));

    assert_no_fall_under_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(clk_p_o) |-> !$past(hold_i));

    assert_jam_parks_n2_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (jam_i && $past(jam_i)) |=> !n2_o);

    assert_jam_parks_post_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (jam_i && $past(jam_i) && !hold_i && !$past(hold_i) && $stable(clk_p_o)
         && !clk_p_o) |=> (!clk_p_o || !jam_i || hold_i || $past(hold_i)) );
endmodule

bind diffclk_scaler dcs_checker chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold_i),
    .jam_i   (jam_i),
    .clk_p_o (clk_p_o),
    .clk_n_o (clk_n_o),
    .n2_o    (n2_o)
);

// File: tb/diffclk_scaler_tb_top.sv
module diffclk_scaler_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0, ref_sel = 1'b0;
    logic [1:0] post_sel = 2'b00;
    logic       aux_clk = 1'b0, aux_load = 1'b0, jam = 1'b0, hold = 1'b0;
    logic [7:0] n1_mod = 8'd2, n2_mod = 8'd2;
    logic       clk_p, clk_n, load, n2;
    int         vectors = 0, fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    diffclk_scaler dut_i (
        .clk_i (clk), .rst_ni (rst_n), .ref_clk_i (ref_clk), .ref_sel_i (ref_sel),
        .post_sel_i (post_sel), .aux_clk_i (aux_clk), .aux_load_i (aux_load),
        .jam_i (jam), .hold_i (hold), .n1_mod_i (n1_mod), .n2_mod_i (n2_mod),
        .clk_p_o (clk_p), .clk_n_o (clk_n), .load_o (load), .n2_o (n2)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int which);
        case (which)
            0:       sig = clk_p;
            1:       sig = load;
            default: sig = n2;
        endcase
    endfunction

    function automatic int exp_mod(input int m);
        exp_mod = (m == 0) ? 1 : m;
    endfunction

    // skip three phases, then check three whole phases
    task automatic meas(input int which, input int exp, input string req);
        for (int t = 0; t < 6; t++) begin
            int   len = 0;
            logic prev = sig(which);
            do begin
                @(negedge clk);
                len++;
            end while (sig(which) == prev && len < 5000);
            if (t >= 3) chk(len == exp, req, len, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int seed = 11;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset levels
        chk(clk_p == 0 && clk_n == 1, "R1 pair", {clk_p, clk_n}, 1);
        chk(load == 0 && n2 == 0, "R1 load/n2", {load, n2}, 0);
        rst_n = 1'b1;

        // R2 / R3 / R4 random settings
        for (int i = 0; i < 8; i++) begin
            int s = $urandom_range(0, 2);
            int k = $urandom_range(0, 9);
            int m = $urandom_range(0, 4);
            post_sel = 2'(s);
            n1_mod   = 8'(k);
            n2_mod   = 8'(m);
            meas(0, 1 << s, "R2 post-scale phase");
            meas(1, exp_mod(k), "R3 load phase");
            meas(2, exp_mod(m) * exp_mod(k), "R4 n2 phase");
        end

        // R3 zero modulus corner
        n1_mod = 8'd0; n2_mod = 8'd3;
        meas(1, 1, "R3 zero modulus");
        meas(2, 3, "R4 over unit load");

        // R6 override outside manual mode, aux_clk ignored
        post_sel = 2'b01; n1_mod = 8'd7; aux_load = 1'b1; aux_clk = 1'b1;
        meas(1, 2, "R6 override load phase");
        meas(0, 2, "R6 aux_clk ignored");
        aux_load = 1'b0; aux_clk = 1'b0;

        // R5 manual mode
        post_sel = 2'b11;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            logic a = 1'($urandom);
            logic b = 1'($urandom);
            aux_clk = a; aux_load = b;
            @(negedge clk);
            chk(clk_p == a && clk_n == !a, "R5 pair follows aux_clk", clk_p, a);
            chk(load == b, "R5 load follows aux_load", load, b);
        end
        n2_mod = 8'd2;
        fork
            repeat (60) begin
                repeat (3) @(negedge clk);
                aux_load = ~aux_load;
            end
            meas(2, 6, "R5 n2 counts manual load");
        join
        aux_load = 1'b0;

        // R8 hold
        post_sel = 2'b00; n1_mod = 8'd2; n2_mod = 8'd2;
        repeat (20) @(negedge clk);
        hold = 1'b1;
        repeat (3) @(negedge clk);
        chk(clk_p == 1 && clk_n == 0, "R8 held level", {clk_p, clk_n}, 2);
        meas(1, 2, "R8 load runs during hold");

        // R9 release
        begin
            bit   bad = 0, rose = 0, released = 0;
            int   after = 0;
            logic prev_n2;
            @(negedge clk);
            hold = 1'b0;
            prev_n2 = n2;
            for (int c = 0; c < 200 && !released; c++) begin
                @(negedge clk);
                if (!rose) begin
                    if (!(clk_p && !clk_n)) bad = 1;
                    if (n2 && !prev_n2) rose = 1;
                    prev_n2 = n2;
                end else begin
                    after++;
                    if (!clk_p) released = 1;
                end
            end
            chk(!bad, "R9 held until n2 rise", bad, 0);
            chk(released && after <= 3, "R9 resumes after n2 rise", after, 3);
        end

        // R10 jam
        n1_mod = 8'd3;
        jam = 1'b1;
        repeat (4) @(negedge clk);
        chk(clk_p == 0 && clk_n == 1, "R10 post-scaler parked", {clk_p, clk_n}, 1);
        chk(n2 == 0, "R10 n2 parked", n2, 0);
        meas(1, 3, "R10 load runs under jam");
        chk(clk_p == 0 && n2 == 0, "R10 still parked", {clk_p, n2}, 0);
        jam = 1'b0;

        // R11 reference ticks, 6 clk cycles each
        ref_sel = 1'b1; post_sel = 2'b01; n1_mod = 8'd2;
        fork
            repeat (200) begin
                repeat (3) @(negedge clk);
                ref_clk = ~ref_clk;
            end
            begin
                meas(0, 12, "R11 post-scale on reference");
                meas(1, 12, "R11 load on reference");
            end
        join
        ref_sel = 1'b0;

        // R12 mid-phase ratio change
        post_sel = 2'b10; n1_mod = 8'd3; n2_mod = 8'd1;
        meas(0, 4, "R12 settle div4");
        begin
            int   len = 0;
            logic prev = clk_p;
            do @(negedge clk); while (clk_p == prev);
            prev = clk_p;
            for (int c = 0; c < 50; c++) begin
                @(negedge clk);
                len++;
                if (len == 2) post_sel = 2'b00;
                if (clk_p != prev) break;
            end
            chk(len == 4, "R12 phase in progress keeps length", len, 4);
            for (int t = 0; t < 2; t++) begin
                prev = clk_p;
                len  = 0;
                do begin @(negedge clk); len++; end while (clk_p == prev && len < 50);
                chk(len == 1, "R12 new ratio next phase", len, 1);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule